// File: doc/BRIEF.md
# I2C Downstream Channel Switch

This block is an I2C target that sits between one upstream bus and a set of downstream bus segments. It holds a single 8-bit control byte. Bit i of that byte connects downstream segment i to the upstream bus. Any subset of segments may be connected at once, including none or all. The segment count is a parameter and is either 4 or 8. The block runs on a system clock and oversamples the upstream SCL and SDA lines. A controller changes the byte with a one-byte write to the switch's own 7-bit address, and reads it back with a one-byte read.

The protocol engine is a single state machine. From IDLE, a START sends it to ADDR, where it shifts in eight bits. At the eighth falling SCL edge it goes to AACK if the address matches and to SKIP if not. When the AACK clock falls, it goes to WDATA for a write or to RDATA for a read. WDATA goes to WACK after each eight-bit byte, and WACK returns to WDATA at the next falling edge. RDATA goes to RACK after eight bits. RACK goes back to RDATA when the controller acknowledges, and to SKIP when it does not. From any state, a START goes to ADDR and a STOP goes to IDLE.

A received byte is held in a shadow register. It is copied into the control byte at STOP only when exactly one data byte was received. Two one-cycle pulses report the outcome of each write: one when the write is committed and one when it is rejected.

Top module: `i2c_chan_switch`

## Requirements
- R1: A write to the own address that carries exactly one data byte loads that byte into `ctrl_o` when the STOP is detected. `commit_o` pulses high for one clock at the same time. `commit_o` and `reject_o` are never high together, and `ctrl_o` changes at no other time.
- R2: For each channel i below `CH_COUNT`, `ch_scl_pull_o[i]` is high exactly when `ctrl_o[i]` is 1 and upstream SCL is low. `ch_sda_pull_o[i]` is high exactly when `ctrl_o[i]` is 1 and upstream SDA is low. Control bits at or above `CH_COUNT` drive no channel.
- R3: A read from the own address returns all 8 bits of `ctrl_o`, most significant bit first. This includes bits at or above `CH_COUNT`. Each further byte that the controller acknowledges returns the same value again.
- R4: A write to the own address with no data byte before STOP pulses `reject_o` and leaves `ctrl_o` unchanged.
- R5: A write to the own address with two or more data bytes acknowledges the first byte and NACKs every later byte. At STOP it pulses `reject_o` and leaves `ctrl_o` unchanged.
- R6: Reset clears `ctrl_o` to 0x00. After reset every channel pull output is low and the switch does not pull upstream SDA.
- R7: The switch acknowledges its own address (`OWN_ADDR`, with R/W in bit 0: 0 = write, 1 = read). It does not acknowledge any other address, and a transaction to another address produces no pulse and no change to `ctrl_o`.
- R8: `sda_pull_o` is high when the switch drives an ACK or a read bit of 0, or when an enabled channel returns SDA low (`ch_sda_ret_i[i]` = 0). A disabled channel's returned SDA has no effect.
- R9: START is an SDA fall while SCL is high, and STOP is an SDA rise while SCL is high. Both are detected after two-flop synchronizers. A STOP always returns the engine to IDLE, and a START always restarts address reception.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock used to oversample the bus |
| rst_n | input | 1 | Asynchronous active-low reset |
| scl_i | input | 1 | Upstream SCL line level |
| sda_i | input | 1 | Upstream SDA line level |
| sda_pull_o | output | 1 | Pulls upstream SDA low when high |
| ch_scl_pull_o | output | CH_COUNT | Per-channel pull-low of downstream SCL |
| ch_sda_pull_o | output | CH_COUNT | Per-channel pull-low of downstream SDA |
| ch_sda_ret_i | input | CH_COUNT | Per-channel downstream SDA level returned upstream |
| ctrl_o | output | 8 | Stored control byte |
| commit_o | output | 1 | One-clock pulse when a write is committed |
| reject_o | output | 1 | One-clock pulse when a write is rejected |

## Verification
The assertions assume that SCL and SDA are held stable for several system clocks around every edge. They also assume that SDA changes only while SCL is low, except at a START or a STOP, so the synchronized edges are never ambiguous. The stimulus meets this by holding each bus phase for sixteen clocks and waiting four clocks after each SCL fall before moving SDA. Downstream targets pull their returned SDA only while SCL is low, so that no false START or STOP is created.

// File: rtl/chsw_pkg.sv
package chsw_pkg;
    typedef enum logic [2:0] {
        ST_IDLE,
        ST_ADDR,
        ST_AACK,
        ST_WDATA,
        ST_WACK,
        ST_RDATA,
        ST_RACK,
        ST_SKIP
    } chsw_state_e;

    localparam int BYTE_W = 8;
endpackage

// File: rtl/chsw_sync.sv
module chsw_sync (
    input  logic clk,
    input  logic rst_n,
    input  logic scl_i,
    input  logic sda_i,
    output logic sda_s_o,
    output logic scl_rise_o,
    output logic scl_fall_o,
    output logic start_o,
    output logic stop_o
);
    logic [1:0] scl_ff, sda_ff;
    logic       scl_p, sda_p;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            scl_ff <= 2'b11;
            sda_ff <= 2'b11;
            scl_p  <= 1'b1;
            sda_p  <= 1'b1;
        end else begin
            scl_ff <= {scl_ff[0], scl_i};
            sda_ff <= {sda_ff[0], sda_i};
            scl_p  <= scl_ff[1];
            sda_p  <= sda_ff[1];
        end
    end

    assign sda_s_o    = sda_ff[1];
    assign scl_rise_o = scl_ff[1] & ~scl_p;
    assign scl_fall_o = ~scl_ff[1] & scl_p;
    assign start_o    = scl_ff[1] & scl_p & sda_p & ~sda_ff[1];
    assign stop_o     = scl_ff[1] & scl_p & ~sda_p & sda_ff[1];
endmodule

// File: rtl/chsw_engine.sv
module chsw_engine
    import chsw_pkg::*;
#(
    parameter logic [6:0] OWN_ADDR = 7'h70
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              sda_s,
    input  logic              scl_rise,
    input  logic              scl_fall,
    input  logic              start_ev,
    input  logic              stop_ev,
    output logic [BYTE_W-1:0] ctrl_o,
    output logic              sda_own_o,
    output logic              commit_o,
    output logic              reject_o
);
    chsw_state_e       state_q, state_d;
    logic [BYTE_W-1:0] shift_q, shadow_q, rd_q;
    logic [3:0]        bit_q;
    logic [1:0]        nbytes_q;
    logic              wr_q, rw_q, more_q;
    logic              addr_hit;

    assign addr_hit = (shift_q[7:1] == OWN_ADDR);

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    // Next state
    always_comb begin
        state_d = state_q;
        if (start_ev) begin
            state_d = ST_ADDR;
        end else if (stop_ev) begin
            state_d = ST_IDLE;
        end else begin
            unique case (state_q)
                ST_IDLE:  state_d = ST_IDLE;
                ST_ADDR:  if (scl_fall && bit_q == 4'd8)
                              state_d = addr_hit ? ST_AACK : ST_SKIP;
                ST_AACK:  if (scl_fall) state_d = rw_q ? ST_RDATA : ST_WDATA;
                ST_WDATA: if (scl_fall && bit_q == 4'd8) state_d = ST_WACK;
                ST_WACK:  if (scl_fall) state_d = ST_WDATA;
                ST_RDATA: if (scl_fall && bit_q == 4'd7) state_d = ST_RACK;
                ST_RACK:  if (scl_fall) state_d = more_q ? ST_RDATA : ST_SKIP;
                ST_SKIP:  state_d = ST_SKIP;
                default:  state_d = ST_IDLE;
            endcase
        end
    end

    // Datapath and outputs
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ctrl_o    <= '0;
            shift_q   <= '0;
            shadow_q  <= '0;
            rd_q      <= '0;
            bit_q     <= '0;
            nbytes_q  <= '0;
            wr_q      <= 1'b0;
            rw_q      <= 1'b0;
            more_q    <= 1'b0;
            sda_own_o <= 1'b0;
            commit_o  <= 1'b0;
            reject_o  <= 1'b0;
        end else begin
            commit_o <= 1'b0;
            reject_o <= 1'b0;
            if (start_ev) begin
                bit_q     <= '0;
                nbytes_q  <= '0;
                wr_q      <= 1'b0;
                sda_own_o <= 1'b0;
            end else if (stop_ev) begin
                sda_own_o <= 1'b0;
                wr_q      <= 1'b0;
                if (wr_q) begin
                    if (nbytes_q == 2'd1) begin
                        ctrl_o   <= shadow_q;
                        commit_o <= 1'b1;
                    end else begin
                        reject_o <= 1'b1;
                    end
                end
            end else begin
                case (state_q)
                    ST_ADDR: begin
                        if (scl_rise) begin
                            shift_q <= {shift_q[6:0], sda_s};
                            bit_q   <= bit_q + 4'd1;
                        end else if (scl_fall && bit_q == 4'd8 && addr_hit) begin
                            sda_own_o <= 1'b1;
                            rw_q      <= shift_q[0];
                        end
                    end
                    ST_AACK: begin
                        if (scl_fall) begin
                            bit_q <= '0;
                            if (rw_q) begin
                                rd_q      <= ctrl_o;
                                sda_own_o <= ~ctrl_o[7];
                            end else begin
                                sda_own_o <= 1'b0;
                                wr_q      <= 1'b1;
                            end
                        end
                    end
                    ST_WDATA: begin
                        if (scl_rise) begin
                            shift_q <= {shift_q[6:0], sda_s};
                            bit_q   <= bit_q + 4'd1;
                        end else if (scl_fall && bit_q == 4'd8) begin
                            if (nbytes_q == 2'd0) begin
                                shadow_q  <= shift_q;
                                sda_own_o <= 1'b1;
                            end
                            if (nbytes_q != 2'd2) nbytes_q <= nbytes_q + 2'd1;
                        end
                    end
                    ST_WACK: begin
                        if (scl_fall) begin
                            sda_own_o <= 1'b0;
                            bit_q     <= '0;
                        end
                    end
                    ST_RDATA: begin
                        if (scl_fall) begin
                            if (bit_q == 4'd7) begin
                                sda_own_o <= 1'b0;
                            end else begin
                                bit_q     <= bit_q + 4'd1;
                                rd_q      <= {rd_q[6:0], 1'b0};
                                sda_own_o <= ~rd_q[6];
                            end
                        end
                    end
                    ST_RACK: begin
                        if (scl_rise) begin
                            more_q <= ~sda_s;
                        end else if (scl_fall && more_q) begin
                            bit_q     <= '0;
                            rd_q      <= ctrl_o;
                            sda_own_o <= ~ctrl_o[7];
                        end
                    end
                    default: ;
                endcase
            end
        end
    end

    p_ctrl_only_on_commit_r1: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(ctrl_o) |-> commit_o);
    p_pulse_exclusive_r1: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({commit_o, reject_o}));
    p_reject_keeps_ctrl_r4: assert property (@(posedge clk) disable iff (!rst_n)
        reject_o |-> $stable(ctrl_o));
    p_stop_to_idle_r9: assert property (@(posedge clk) disable iff (!rst_n)
        stop_ev && !start_ev |=> state_q == ST_IDLE);
    p_start_to_addr_r9: assert property (@(posedge clk) disable iff (!rst_n)
        start_ev |=> state_q == ST_ADDR && bit_q == 4'd0);
    p_skip_silent_r7: assert property (@(posedge clk) disable iff (!rst_n)
        state_q == ST_SKIP |-> !sda_own_o);
endmodule

// File: rtl/chsw_gate.sv
module chsw_gate #(
    parameter int CH_COUNT = 4
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic [7:0]          ctrl_i,
    input  logic                scl_i,
    input  logic                sda_i,
    input  logic                own_pull_i,
    input  logic [CH_COUNT-1:0] ch_sda_ret_i,
    output logic [CH_COUNT-1:0] ch_scl_pull_o,
    output logic [CH_COUNT-1:0] ch_sda_pull_o,
    output logic                sda_pull_o
);
    logic [CH_COUNT-1:0] ret_low;

    for (genvar i = 0; i < CH_COUNT; i++) begin : g_ch
        assign ch_scl_pull_o[i] = ctrl_i[i] & ~scl_i;
        assign ch_sda_pull_o[i] = ctrl_i[i] & ~sda_i;
        assign ret_low[i]       = ctrl_i[i] & ~ch_sda_ret_i[i];
    end

    assign sda_pull_o = own_pull_i | (|ret_low);

    p_released_when_quiet_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (!own_pull_i && (&ch_sda_ret_i)) |-> !sda_pull_o);
    p_disabled_no_drive_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (ctrl_i[CH_COUNT-1:0] == '0) |-> (ch_scl_pull_o == '0 && ch_sda_pull_o == '0));
endmodule

// File: rtl/i2c_chan_switch.sv
module i2c_chan_switch #(
    parameter int         CH_COUNT = 4,
    parameter logic [6:0] OWN_ADDR = 7'h70
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                scl_i,
    input  logic                sda_i,
    output logic                sda_pull_o,
    output logic [CH_COUNT-1:0] ch_scl_pull_o,
    output logic [CH_COUNT-1:0] ch_sda_pull_o,
    input  logic [CH_COUNT-1:0] ch_sda_ret_i,
    output logic [7:0]          ctrl_o,
    output logic                commit_o,
    output logic                reject_o
);
    logic sda_s, scl_rise, scl_fall, start_ev, stop_ev, sda_own;

    chsw_sync u_sync (
        .clk        (clk),
        .rst_n      (rst_n),
        .scl_i      (scl_i),
        .sda_i      (sda_i),
        .sda_s_o    (sda_s),
        .scl_rise_o (scl_rise),
        .scl_fall_o (scl_fall),
        .start_o    (start_ev),
        .stop_o     (stop_ev)
    );

    chsw_engine #(.OWN_ADDR(OWN_ADDR)) u_engine (
        .clk       (clk),
        .rst_n     (rst_n),
        .sda_s     (sda_s),
        .scl_rise  (scl_rise),
        .scl_fall  (scl_fall),
        .start_ev  (start_ev),
        .stop_ev   (stop_ev),
        .ctrl_o    (ctrl_o),
        .sda_own_o (sda_own),
        .commit_o  (commit_o),
        .reject_o  (reject_o)
    );

    chsw_gate #(.CH_COUNT(CH_COUNT)) u_gate (
        .clk           (clk),
        .rst_n         (rst_n),
        .ctrl_i        (ctrl_o),
        .scl_i         (scl_i),
        .sda_i         (sda_i),
        .own_pull_i    (sda_own),
        .ch_sda_ret_i  (ch_sda_ret_i),
        .ch_scl_pull_o (ch_scl_pull_o),
        .ch_sda_pull_o (ch_sda_pull_o),
        .sda_pull_o    (sda_pull_o)
    );
endmodule

// File: tb/i2c_chan_switch_bench.sv
module i2c_chan_switch_bench;
    localparam int         N   = 4;
    localparam logic [6:0] ADR = 7'h70;
    localparam int         H   = 16;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic m_scl = 1'b1, m_sda = 1'b1;
    logic [N-1:0] ds_pull = '0;
    logic sda_pull;
    logic [N-1:0] ch_scl_pull, ch_sda_pull;
    logic [7:0] ctrl;
    logic commit, reject;
    wire scl_line = m_scl;
    wire sda_line = m_sda & ~sda_pull;

    int checks = 0, errors = 0, n_commit = 0, n_reject = 0, wd = 0;
    logic [7:0] model_ctrl = 8'h00;
    bit settle = 1'b1;

    always #10 clk = ~clk;

    i2c_chan_switch #(.CH_COUNT(N), .OWN_ADDR(ADR)) u_i2c_chan_switch (
        .clk(clk), .rst_n(rst_n), .scl_i(scl_line), .sda_i(sda_line),
        .sda_pull_o(sda_pull), .ch_scl_pull_o(ch_scl_pull), .ch_sda_pull_o(ch_sda_pull),
        .ch_sda_ret_i(~ds_pull), .ctrl_o(ctrl), .commit_o(commit), .reject_o(reject));

    task automatic chk(input string what, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", what, act, exp);
        end
    endtask

    // Per-clock reference comparison and pulse counting
    always @(negedge clk) begin
        if (rst_n) begin
            if (commit) n_commit++;
            if (reject) n_reject++;
            if (!settle) begin
                chk("R1 ctrl vs model", 32'(ctrl), 32'(model_ctrl));
                chk("R2 scl gating", 32'(ch_scl_pull), 32'(model_ctrl[N-1:0] & {N{~scl_line}}));
                chk("R2 sda gating", 32'(ch_sda_pull), 32'(model_ctrl[N-1:0] & {N{~sda_line}}));
            end
        end
    end

    always @(posedge clk) begin
        wd++;
        if (wd == 150000) begin
            errors++;
            $display("FAIL watchdog actual=%0d expected=<%0d", wd, 150000);
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    task automatic tick(input int n);
        repeat (n) @(posedge clk);
    endtask

    task automatic i2c_start();
        m_sda = 1'b1; m_scl = 1'b1; tick(H);
        m_sda = 1'b0; tick(H);
        m_scl = 1'b0; tick(4);
    endtask

    task automatic i2c_stop(input logic [7:0] nxt);
        m_sda = 1'b0; tick(H);
        m_scl = 1'b1; tick(H);
        settle = 1'b1;
        m_sda = 1'b1; tick(H);
        model_ctrl = nxt;
        settle = 1'b0;
        tick(H);
    endtask

    task automatic send_byte(input logic [7:0] b, output logic ack);
        for (int i = 7; i >= 0; i--) begin
            m_sda = b[i]; tick(H);
            m_scl = 1'b1; tick(H);
            m_scl = 1'b0; tick(4);
        end
        m_sda = 1'b1; tick(H);
        m_scl = 1'b1; tick(H/2);
        ack = ~sda_line; tick(H/2);
        m_scl = 1'b0; tick(4);
    endtask

    task automatic recv_byte(output logic [7:0] v, input logic give_ack);
        m_sda = 1'b1;
        v = '0;
        for (int i = 0; i < 8; i++) begin
            tick(H);
            m_scl = 1'b1; tick(H/2);
            v = {v[6:0], sda_line}; tick(H/2);
            m_scl = 1'b0; tick(4);
        end
        m_sda = ~give_ack; tick(H);
        m_scl = 1'b1; tick(H);
        m_scl = 1'b0; tick(4);
    endtask

    task automatic write1(input logic [7:0] b);
        logic a;
        i2c_start();
        send_byte({ADR, 1'b0}, a); chk("R7 own address ack", 32'(a), 1);
        send_byte(b, a);           chk("R1 data byte ack", 32'(a), 1);
        i2c_stop(b);
    endtask

    task automatic read_check(input string what);
        logic a;
        logic [7:0] v;
        i2c_start();
        send_byte({ADR, 1'b1}, a); chk("R7 read address ack", 32'(a), 1);
        recv_byte(v, 1'b0);        chk(what, 32'(v), 32'(model_ctrl));
        i2c_stop(model_ctrl);
    endtask

    initial begin
        logic a;
        logic [7:0] v;
        tick(5);
        @(negedge clk);
        chk("R6 reset ctrl", 32'(ctrl), 0);
        chk("R6 reset scl pulls", 32'(ch_scl_pull), 0);
        chk("R6 reset sda pulls", 32'(ch_sda_pull), 0);
        chk("R6 reset upstream pull", 32'(sda_pull), 0);
        rst_n = 1'b1;
        tick(4);
        settle = 1'b0;

        // R1: single-byte write commits at STOP
        write1(8'h05);
        chk("R1 commit count", n_commit, 1);
        read_check("R3 readback 05");

        // R3: bits above the channel count are stored and read back
        write1(8'hA6);
        chk("R1 commit count", n_commit, 2);
        read_check("R3 readback A6 upper bits");

        // R4: zero-byte write
        i2c_start();
        send_byte({ADR, 1'b0}, a); chk("R7 own address ack", 32'(a), 1);
        i2c_stop(model_ctrl);
        chk("R4 reject count", n_reject, 1);
        chk("R4 ctrl unchanged", 32'(ctrl), 32'h A6);

        // R5: two-byte write
        i2c_start();
        send_byte({ADR, 1'b0}, a);
        send_byte(8'h11, a); chk("R5 first byte ack", 32'(a), 1);
        send_byte(8'h22, a); chk("R5 second byte nack", 32'(a), 0);
        i2c_stop(model_ctrl);
        chk("R5 reject count", n_reject, 2);
        chk("R5 ctrl unchanged", 32'(ctrl), 32'h A6);
        chk("R5 no commit", n_commit, 2);

        // R7 and R8: foreign address, downstream SDA return
        i2c_start();
        send_byte({7'h50, 1'b0}, a); chk("R7 foreign address nack", 32'(a), 0);
        ds_pull[0] = 1'b1; tick(4);
        @(negedge clk); chk("R8 disabled channel ignored", 32'(sda_pull), 0);
        ds_pull[0] = 1'b0; ds_pull[2] = 1'b1; tick(4);
        @(negedge clk); chk("R8 enabled channel pulls upstream", 32'(sda_pull), 1);
        ds_pull[2] = 1'b0; tick(4);
        i2c_stop(model_ctrl);
        chk("R7 no pulses on foreign", n_commit + n_reject, 4);
        chk("R7 ctrl unchanged", 32'(ctrl), 32'h A6);

        // R3: repeated read bytes with controller ACK
        i2c_start();
        send_byte({ADR, 1'b1}, a);
        recv_byte(v, 1'b1); chk("R3 first read byte", 32'(v), 32'h A6);
        recv_byte(v, 1'b0); chk("R3 second read byte", 32'(v), 32'h A6);
        i2c_stop(model_ctrl);

        // R2: all and none enabled
        write1(8'hFF);
        read_check("R3 readback FF");
        write1(8'h00);
        chk("R1 commit count final", n_commit, 4);

        tick(10);
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule